// File: doc/BRIEF.md
# Two-Word-Burst Quad-Rate SRAM Request Controller

This controller sits between two independent user request streams, one for reads and one for writes, and a synchronous SRAM that moves every access as a two-word burst. Each user port has a four-entry queue behind a ready/valid handshake. In every clock cycle the controller can launch one read and one write together. It drives a per-half-cycle view of the memory pins. The read address goes with the first half of the cycle, together with the active-low read and write selects. The write address goes with the second half. Write word 0 and its active-low byte masks go with the first half, and word 1 and its masks with the second half. A physical layer outside this block folds each pair of half-cycle outputs onto the shared double-rate pins.

After reset the controller waits a fixed number of cycles for the memory's output clock loop to lock. It then issues whatever is queued. The memory returns each read burst a fixed number of cycles after the command. The controller captures both words and hands them to the user as one two-word beat, together with a rolling tag in issue order. When a read and a write to the same address launch in the same cycle, the controller relies on the memory to forward the new data.

The issue state machine has five states. `ST_INIT` is the lock wait. `ST_NOP` means nothing was launched this cycle, `ST_RD` means a read only, `ST_WR` means a write only, and `ST_RDWR` means both. Reset enters `ST_INIT`. `ST_INIT` stays in place until its counter reaches `INIT_CYC-1`. From then on, on every cycle, the next state is chosen from which queues are non-empty: neither gives `ST_NOP`, the read queue only gives `ST_RD`, the write queue only gives `ST_WR`, and both give `ST_RDWR`. The same choice applies from every run state, including the exit from `ST_INIT`.

Top module: `qdr_b2_ctrl`

## Requirements
- R1: During and directly after reset, `rd_ready` and `wr_ready` are 1, `mem_rd_n` and `mem_wr_n` are 1, and `rsp_valid` is 0.
- R2: For `INIT_CYC` cycles after reset no command is issued (`mem_rd_n` = `mem_wr_n` = 1). Requests offered in that time are still accepted into the queues.
- R3: Each port holds up to `DEPTH` (4) accepted requests. Its ready output is 0 while that many are pending. Queued requests leave in acceptance order, so of two writes to one address the later one wins.
- R4: At most one read and one write are issued per cycle. When both queues hold a request, both are issued in the same cycle.
- R5: A read drives `mem_addr_ph0` and a write drives `mem_addr_ph1`. In a cycle without a read, `mem_addr_ph0` keeps its previous value. In a cycle without a write, `mem_addr_ph1` keeps its previous value.
- R6: A write drives word 0 on `mem_d_ph0` with masks `mem_bw_n_ph0`, and word 1 on `mem_d_ph1` with masks `mem_bw_n_ph1`. Mask bit i is active-low and guards data bits [8i+7:8i]. It is the inverse of user enable bit i (`wr_be0`/`wr_be1`).
- R7: A write whose enables for one word are all 0 leaves that stored word unchanged.
- R8: A read whose command is on the pins in cycle c produces `rsp_valid` = 1 in cycle c+`RD_LAT`+1. `rsp_data0`/`rsp_data1` carry the memory words that were presented on `mem_q_ph0`/`mem_q_ph1` in cycle c+`RD_LAT`.
- R9: `rsp_tag` counts issued reads modulo 2^`TAG_W`, starting at 0 after reset, so responses arrive in issue order.
- R10: A read and a write to the same address accepted in the same cycle are issued together. The read returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; its two halves are the two capture phases |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue can accept |
| rd_addr | input | ADDR_W | Burst address of the read |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write queue can accept |
| wr_addr | input | ADDR_W | Burst address of the write |
| wr_data0 | input | DATA_W | First word of the write burst |
| wr_data1 | input | DATA_W | Second word of the write burst |
| wr_be0 | input | DATA_W/8 | Active-high byte enables for word 0 |
| wr_be1 | input | DATA_W/8 | Active-high byte enables for word 1 |
| rsp_valid | output | 1 | Read beat valid |
| rsp_data0 | output | DATA_W | First returned word |
| rsp_data1 | output | DATA_W | Second returned word |
| rsp_tag | output | TAG_W | Issue-order tag of the beat |
| mem_rd_n | output | 1 | Active-low read select, first half |
| mem_wr_n | output | 1 | Active-low write select, first half |
| mem_addr_ph0 | output | ADDR_W | Address for the first half (read) |
| mem_addr_ph1 | output | ADDR_W | Address for the second half (write) |
| mem_d_ph0 | output | DATA_W | Write word 0, first half |
| mem_d_ph1 | output | DATA_W | Write word 1, second half |
| mem_bw_n_ph0 | output | DATA_W/8 | Active-low byte masks, first half |
| mem_bw_n_ph1 | output | DATA_W/8 | Active-low byte masks, second half |
| mem_q_ph0 | input | DATA_W | Returned read word 0 |
| mem_q_ph1 | input | DATA_W | Returned read word 1 |

## Verification
The bench fills the write queue during the lock wait and expects ready to drop on the fourth entry. A controller that issued too early would put a write select on the pins, and one that miscounted its depth would show the wrong ready. Two writes to one address in the lock wait, read back later, expose any reordering. Mixed partial masks and an all-disabled word catch swapped phases or mask polarity errors, which corrupt or clobber stored bytes. A single read is timed edge by edge against the fixed latency while the idle write address is watched for drift. A same-cycle read and write to one address must both appear in one cycle and return the new data; a controller that serialized them, or let the read overtake the write, returns stale words or wrong tags.

// File: rtl/qdrc_pkg.sv
package qdrc_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_NOP,
        ST_RD,
        ST_WR,
        ST_RDWR
    } issue_st_e;
endpackage

// File: rtl/qdrc_req_fifo.sv
module qdrc_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    input  logic             pop,
    output logic             nonempty,
    output logic [WIDTH-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push;

    assign in_ready = (cnt_q != CNT_W'(DEPTH));
    assign push     = in_valid && in_ready;
    assign nonempty = (cnt_q != '0);
    assign out_data = slot_q[rptr_q];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= step(wptr_q);
            if (pop)  rptr_q <= step(rptr_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[wptr_q] <= in_data;
    end

    // R3: occupancy never exceeds the queue depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));
    // R4: the issue logic only pops a queue that holds a request
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/qdrc_issue.sv
module qdrc_issue
    import qdrc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int INIT_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_pending,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  wr_pending,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_d0,
    input  logic [DATA_W-1:0]     wr_d1,
    input  logic [DATA_W/8-1:0]   wr_be0,
    input  logic [DATA_W/8-1:0]   wr_be1,
    output logic                  rd_go,
    output logic                  wr_go,
    output logic                  mem_rd_n,
    output logic                  mem_wr_n,
    output logic [ADDR_W-1:0]     mem_addr_ph0,
    output logic [ADDR_W-1:0]     mem_addr_ph1,
    output logic [DATA_W-1:0]     mem_d_ph0,
    output logic [DATA_W-1:0]     mem_d_ph1,
    output logic [DATA_W/8-1:0]   mem_bw_n_ph0,
    output logic [DATA_W/8-1:0]   mem_bw_n_ph1
);
    localparam int CNT_W = $clog2(INIT_CYC + 1);

    issue_st_e       st_q, st_nxt;
    logic [CNT_W-1:0] init_cnt_q;
    logic            init_done;
    issue_st_e       run_pick;

    assign init_done = (init_cnt_q == CNT_W'(INIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst)                 init_cnt_q <= '0;
        else if (st_q == ST_INIT) init_cnt_q <= init_cnt_q + 1'b1;
    end

    always_comb begin
        unique case ({rd_pending, wr_pending})
            2'b11:   run_pick = ST_RDWR;
            2'b10:   run_pick = ST_RD;
            2'b01:   run_pick = ST_WR;
            default: run_pick = ST_NOP;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_INIT: st_nxt = init_done ? run_pick : ST_INIT;
            ST_NOP, ST_RD, ST_WR, ST_RDWR: st_nxt = run_pick;
            default: st_nxt = ST_INIT;
        endcase
    end

    always_comb begin
        unique case (st_nxt)
            ST_RD:   begin rd_go = 1'b1; wr_go = 1'b0; end
            ST_WR:   begin rd_go = 1'b0; wr_go = 1'b1; end
            ST_RDWR: begin rd_go = 1'b1; wr_go = 1'b1; end
            default: begin rd_go = 1'b0; wr_go = 1'b0; end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_INIT;
        else     st_q <= st_nxt;
    end

    // registered pin outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd_n     <= 1'b1;
            mem_wr_n     <= 1'b1;
            mem_addr_ph0 <= '0;
            mem_addr_ph1 <= '0;
            mem_d_ph0    <= '0;
            mem_d_ph1    <= '0;
            mem_bw_n_ph0 <= '1;
            mem_bw_n_ph1 <= '1;
        end else begin
            mem_rd_n <= ~rd_go;
            mem_wr_n <= ~wr_go;
            if (rd_go) mem_addr_ph0 <= rd_addr;
            if (wr_go) begin
                mem_addr_ph1 <= wr_addr;
                mem_d_ph0    <= wr_d0;
                mem_d_ph1    <= wr_d1;
                mem_bw_n_ph0 <= ~wr_be0;
                mem_bw_n_ph1 <= ~wr_be1;
            end
        end
    end

    // R2: no command reaches the pins while waiting for lock
    p_init_nop_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_INIT) |-> (mem_rd_n && mem_wr_n));
    // R5: read-phase address holds when no read is on the pins
    p_addr_hold_ph0_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_n |-> $stable(mem_addr_ph0));
    // R5: write-phase address holds when no write is on the pins
    p_addr_hold_ph1_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_n |-> $stable(mem_addr_ph1));
endmodule

// File: rtl/qdrc_rd_return.sv
module qdrc_rd_return #(
    parameter int DATA_W = 16,
    parameter int RD_LAT = 2,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_rd,
    input  logic [DATA_W-1:0] mem_q0,
    input  logic [DATA_W-1:0] mem_q1,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_d0,
    output logic [DATA_W-1:0] rsp_d1,
    output logic [TAG_W-1:0]  rsp_tag
);
    logic [RD_LAT:0]    vld_q;
    logic [TAG_W-1:0]   tag_q [RD_LAT+1];
    logic [TAG_W-1:0]   tag_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q     <= '0;
            tag_cnt_q <= '0;
        end else begin
            vld_q <= {vld_q[RD_LAT-1:0], issue_rd};
            if (issue_rd) tag_cnt_q <= tag_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (issue_rd) tag_q[0] <= tag_cnt_q;
    end

    for (genvar k = 1; k <= RD_LAT; k++) begin : g_tag_stage
        always_ff @(posedge clk) begin
            tag_q[k] <= tag_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_d0    <= '0;
            rsp_d1    <= '0;
            rsp_tag   <= '0;
        end else begin
            rsp_valid <= vld_q[RD_LAT];
            if (vld_q[RD_LAT]) begin
                rsp_d0  <= mem_q0;
                rsp_d1  <= mem_q1;
                rsp_tag <= tag_q[RD_LAT];
            end
        end
    end
endmodule

// File: rtl/qdr_b2_ctrl.sv
module qdr_b2_ctrl #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 4,
    parameter int RD_LAT   = 2,
    parameter int TAG_W    = 2,
    parameter int INIT_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_valid,
    output logic                  rd_ready,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data0,
    input  logic [DATA_W-1:0]     wr_data1,
    input  logic [DATA_W/8-1:0]   wr_be0,
    input  logic [DATA_W/8-1:0]   wr_be1,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_data0,
    output logic [DATA_W-1:0]     rsp_data1,
    output logic [TAG_W-1:0]      rsp_tag,
    output logic                  mem_rd_n,
    output logic                  mem_wr_n,
    output logic [ADDR_W-1:0]     mem_addr_ph0,
    output logic [ADDR_W-1:0]     mem_addr_ph1,
    output logic [DATA_W-1:0]     mem_d_ph0,
    output logic [DATA_W-1:0]     mem_d_ph1,
    output logic [DATA_W/8-1:0]   mem_bw_n_ph0,
    output logic [DATA_W/8-1:0]   mem_bw_n_ph1,
    input  logic [DATA_W-1:0]     mem_q_ph0,
    input  logic [DATA_W-1:0]     mem_q_ph1
);
    localparam int NBYTE = DATA_W / 8;
    localparam int WENT_W = ADDR_W + 2 * DATA_W + 2 * NBYTE;

    logic              rd_pend, wr_pend, rd_go, wr_go;
    logic [ADDR_W-1:0] rq_addr;
    logic [WENT_W-1:0] wq_ent;
    logic [ADDR_W-1:0] wq_addr;
    logic [DATA_W-1:0] wq_d0, wq_d1;
    logic [NBYTE-1:0]  wq_be0, wq_be1;

    assign {wq_addr, wq_d0, wq_d1, wq_be0, wq_be1} = wq_ent;

    qdrc_req_fifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_rd_q (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rd_valid),
        .in_ready (rd_ready),
        .in_data  (rd_addr),
        .pop      (rd_go),
        .nonempty (rd_pend),
        .out_data (rq_addr)
    );

    qdrc_req_fifo #(.WIDTH(WENT_W), .DEPTH(DEPTH)) u_wr_q (
        .clk      (clk),
        .rst      (rst),
        .in_valid (wr_valid),
        .in_ready (wr_ready),
        .in_data  ({wr_addr, wr_data0, wr_data1, wr_be0, wr_be1}),
        .pop      (wr_go),
        .nonempty (wr_pend),
        .out_data (wq_ent)
    );

    qdrc_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_CYC(INIT_CYC)) u_issue (
        .clk          (clk),
        .rst          (rst),
        .rd_pending   (rd_pend),
        .rd_addr      (rq_addr),
        .wr_pending   (wr_pend),
        .wr_addr      (wq_addr),
        .wr_d0        (wq_d0),
        .wr_d1        (wq_d1),
        .wr_be0       (wq_be0),
        .wr_be1       (wq_be1),
        .rd_go        (rd_go),
        .wr_go        (wr_go),
        .mem_rd_n     (mem_rd_n),
        .mem_wr_n     (mem_wr_n),
        .mem_addr_ph0 (mem_addr_ph0),
        .mem_addr_ph1 (mem_addr_ph1),
        .mem_d_ph0    (mem_d_ph0),
        .mem_d_ph1    (mem_d_ph1),
        .mem_bw_n_ph0 (mem_bw_n_ph0),
        .mem_bw_n_ph1 (mem_bw_n_ph1)
    );

    qdrc_rd_return #(.DATA_W(DATA_W), .RD_LAT(RD_LAT), .TAG_W(TAG_W)) u_ret (
        .clk       (clk),
        .rst       (rst),
        .issue_rd  (rd_go),
        .mem_q0    (mem_q_ph0),
        .mem_q1    (mem_q_ph1),
        .rsp_valid (rsp_valid),
        .rsp_d0    (rsp_data0),
        .rsp_d1    (rsp_data1),
        .rsp_tag   (rsp_tag)
    );

    // R8: a read on the pins is answered a fixed number of cycles later
    p_read_latency_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> ##(RD_LAT + 1) rsp_valid);
endmodule

// File: tb/qdr_b2_ctrl_tb.sv
module qdr_b2_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NB = DW / 8;
    localparam int LAT = 2;
    localparam int TW = 2;
    localparam int INIT = 16;
    localparam int VW = 1 + AW + 2 * DW + 2 * NB;
    localparam int NVEC = 10;

    // {is_write, addr, word0, word1, be0, be1}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b1, 8'h20, 16'hC0DE, 16'hF00D, 2'b11, 2'b11},
        {1'b1, 8'h21, 16'h1111, 16'h2222, 2'b11, 2'b11},
        {1'b1, 8'h20, 16'hBEEF, 16'h9999, 2'b00, 2'b11},
        {1'b1, 8'h21, 16'hABCD, 16'h6789, 2'b10, 2'b01},
        {1'b0, 8'h20, 16'h0000, 16'h0000, 2'b00, 2'b00},
        {1'b0, 8'h21, 16'h0000, 16'h0000, 2'b00, 2'b00},
        {1'b0, 8'h05, 16'h0000, 16'h0000, 2'b00, 2'b00},
        {1'b0, 8'h06, 16'h0000, 16'h0000, 2'b00, 2'b00},
        {1'b0, 8'h07, 16'h0000, 16'h0000, 2'b00, 2'b00},
        {1'b0, 8'h20, 16'h0000, 16'h0000, 2'b00, 2'b00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_valid = 1'b0, wr_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [DW-1:0] wr_data0 = '0, wr_data1 = '0;
    logic [NB-1:0] wr_be0 = '0, wr_be1 = '0;
    logic rd_ready, wr_ready, rsp_valid, mem_rd_n, mem_wr_n;
    logic [DW-1:0] rsp_data0, rsp_data1, mem_d_ph0, mem_d_ph1, mem_q_ph0, mem_q_ph1;
    logic [TW-1:0] rsp_tag;
    logic [AW-1:0] mem_addr_ph0, mem_addr_ph1;
    logic [NB-1:0] mem_bw_n_ph0, mem_bw_n_ph1;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qdr_b2_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .RD_LAT(LAT),
                  .TAG_W(TW), .INIT_CYC(INIT)) u_dut (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_be0(wr_be0), .wr_be1(wr_be1),
        .rsp_valid(rsp_valid), .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
        .rsp_tag(rsp_tag),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_addr_ph0(mem_addr_ph0), .mem_addr_ph1(mem_addr_ph1),
        .mem_d_ph0(mem_d_ph0), .mem_d_ph1(mem_d_ph1),
        .mem_bw_n_ph0(mem_bw_n_ph0), .mem_bw_n_ph1(mem_bw_n_ph1),
        .mem_q_ph0(mem_q_ph0), .mem_q_ph1(mem_q_ph1)
    );

    // SRAM model: write lands first, so a same-cycle read sees it
    logic [DW-1:0] m0 [256];
    logic [DW-1:0] m1 [256];
    logic [2*DW-1:0] qpipe [LAT];
    assign mem_q_ph0 = qpipe[LAT-1][DW-1:0];
    assign mem_q_ph1 = qpipe[LAT-1][2*DW-1:DW];

    always @(posedge clk) begin
        if (!mem_wr_n) begin
            for (int b = 0; b < NB; b++) begin
                if (!mem_bw_n_ph0[b]) m0[mem_addr_ph1][8*b +: 8] = mem_d_ph0[8*b +: 8];
                if (!mem_bw_n_ph1[b]) m1[mem_addr_ph1][8*b +: 8] = mem_d_ph1[8*b +: 8];
            end
        end
        if (!mem_rd_n) qpipe[0] <= {m1[mem_addr_ph0], m0[mem_addr_ph0]};
        for (int k = 1; k < LAT; k++) qpipe[k] <= qpipe[k-1];
    end

    // shadow of expected contents and expected response queue
    logic [DW-1:0] sh0 [256];
    logic [DW-1:0] sh1 [256];
    logic [DW-1:0] exp0 [64];
    logic [DW-1:0] exp1 [64];
    string         explbl [64];
    int exp_wr = 0;
    int exp_rd = 0;

    task automatic check(input bit ok, input string lbl,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
        end
    endtask

    task automatic shadow_write(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                                input logic [DW-1:0] d1, input logic [NB-1:0] e0,
                                input logic [NB-1:0] e1);
        for (int b = 0; b < NB; b++) begin
            if (e0[b]) sh0[a][8*b +: 8] = d0[8*b +: 8];
            if (e1[b]) sh1[a][8*b +: 8] = d1[8*b +: 8];
        end
    endtask

    task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                           input logic [DW-1:0] d1, input logic [NB-1:0] e0,
                           input logic [NB-1:0] e1);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data0 = d0; wr_data1 = d1;
        wr_be0 = e0; wr_be1 = e1;
        @(posedge clk);
        shadow_write(a, d0, d1, e0, e1);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic push_rd(input logic [AW-1:0] a, input string lbl);
        while (!rd_ready) @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(posedge clk);
        exp0[exp_wr] = sh0[a]; exp1[exp_wr] = sh1[a]; explbl[exp_wr] = lbl;
        exp_wr++;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // response monitor: data in order, tag = issue index mod 4 (R8, R9)
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_rd >= exp_wr) begin
                check(1'b0, "R8 unexpected rsp_valid", 32'(rsp_data0), 32'hFFFF_FFFF);
            end else begin
                check(rsp_data0 == exp0[exp_rd], {explbl[exp_rd], " word0"},
                      32'(rsp_data0), 32'(exp0[exp_rd]));
                check(rsp_data1 == exp1[exp_rd], {explbl[exp_rd], " word1"},
                      32'(rsp_data1), 32'(exp1[exp_rd]));
                check(rsp_tag == TW'(exp_rd), "R9 tag order",
                      32'(rsp_tag), 32'(exp_rd % (1 << TW)));
                exp_rd++;
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin sh0[i] = '0; sh1[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(rd_ready && wr_ready, "R1 ready in reset", {rd_ready, wr_ready}, 2'b11);
        check(mem_rd_n && mem_wr_n, "R1 selects idle", {mem_rd_n, mem_wr_n}, 2'b11);
        check(!rsp_valid, "R1 rsp_valid low", 32'(rsp_valid), 0);
        rst = 1'b0;

        // R2/R3: fill write queue during lock wait; same address twice keeps order
        push_wr(8'h05, 16'hAAAA, 16'hBBBB, 2'b11, 2'b11);
        push_wr(8'h05, 16'h1234, 16'h5678, 2'b01, 2'b10);
        push_wr(8'h06, 16'h0F0F, 16'hF0F0, 2'b11, 2'b11);
        push_wr(8'h07, 16'h7777, 16'h8888, 2'b11, 2'b11);
        check(!wr_ready, "R3 ready low when four pending", 32'(wr_ready), 0);
        check(mem_wr_n && mem_rd_n, "R2 no command in lock wait",
              {mem_rd_n, mem_wr_n}, 2'b11);
        repeat (INIT + 8) @(negedge clk);
        check(wr_ready, "R3 ready back after drain", 32'(wr_ready), 1);

        // table: R6 phase/mask placement, R7 suppressed word, R3 order
        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            if (v[VW-1])
                push_wr(v[VW-2 -: AW], v[2*DW+2*NB-1 -: DW], v[DW+2*NB-1 -: DW],
                        v[2*NB-1 -: NB], v[NB-1:0]);
            else
                push_rd(v[VW-2 -: AW], "R6 R7 R3 table read");
        end
        repeat (10) @(negedge clk);

        // R8 latency and R5 phase addresses
        rd_valid = 1'b1; rd_addr = 8'h06;
        @(posedge clk);
        exp0[exp_wr] = sh0[8'h06]; exp1[exp_wr] = sh1[8'h06];
        explbl[exp_wr] = "R8 timed read"; exp_wr++;
        @(negedge clk);
        rd_valid = 1'b0;
        check(mem_rd_n, "R8 no command yet", 32'(mem_rd_n), 1);
        @(negedge clk);
        check(!mem_rd_n && mem_wr_n, "R5 read only on pins", {mem_rd_n, mem_wr_n}, 2'b01);
        check(mem_addr_ph0 == 8'h06, "R5 read address phase 0", 32'(mem_addr_ph0), 32'h06);
        check(mem_addr_ph1 == 8'h21, "R5 write address held", 32'(mem_addr_ph1), 32'h21);
        repeat (LAT) @(negedge clk);
        check(!rsp_valid, "R8 not early", 32'(rsp_valid), 0);
        @(negedge clk);
        check(rsp_valid, "R8 response at latency", 32'(rsp_valid), 1);
        @(negedge clk);
        check(mem_addr_ph0 == 8'h06 && mem_rd_n, "R5 read address held in NOP",
              32'(mem_addr_ph0), 32'h06);

        // R4/R10: same-cycle read and write, same address
        rd_valid = 1'b1; rd_addr = 8'h30;
        wr_valid = 1'b1; wr_addr = 8'h30; wr_data0 = 16'h4242; wr_data1 = 16'h2424;
        wr_be0 = 2'b11; wr_be1 = 2'b11;
        @(posedge clk);
        shadow_write(8'h30, 16'h4242, 16'h2424, 2'b11, 2'b11);
        exp0[exp_wr] = 16'h4242; exp1[exp_wr] = 16'h2424;
        explbl[exp_wr] = "R10 forwarded read"; exp_wr++;
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        @(negedge clk);
        check(!mem_rd_n && !mem_wr_n, "R4 both issued together",
              {mem_rd_n, mem_wr_n}, 2'b00);
        check(mem_addr_ph0 == 8'h30 && mem_addr_ph1 == 8'h30, "R10 both phases same address",
              {mem_addr_ph0, mem_addr_ph1}, 16'h3030);
        check(mem_d_ph0 == 16'h4242 && mem_d_ph1 == 16'h2424, "R6 words per phase",
              {mem_d_ph0, mem_d_ph1}, 32'h4242_2424);

        // R4 different addresses together
        rd_valid = 1'b1; rd_addr = 8'h05;
        wr_valid = 1'b1; wr_addr = 8'h31; wr_data0 = 16'h0001; wr_data1 = 16'h0002;
        @(posedge clk);
        shadow_write(8'h31, 16'h0001, 16'h0002, 2'b11, 2'b11);
        exp0[exp_wr] = sh0[8'h05]; exp1[exp_wr] = sh1[8'h05];
        explbl[exp_wr] = "R4 read beside write"; exp_wr++;
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        push_rd(8'h31, "R4 write landed");
        repeat (12) @(negedge clk);
        check(exp_rd == exp_wr, "R8 all responses returned", 32'(exp_rd), 32'(exp_wr));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule